// File: doc/BRIEF.md
# Four-Axis Counter Host Register Interface

This block is the byte-wide host port of a four-axis counter. A host picks one of eight register slots with a 3-bit register select and one axis with a 2-bit axis select. It qualifies each access with active-low chip-select, read and write strobes. Through this port the host sets two mode bytes per axis and loads a 24-bit preset value one byte at a time. It reads back a 24-bit snapshot of the counter one byte at a time, and it reads a sticky status byte. The counters themselves sit outside this block. They receive the mode bytes, the preset value and single-clock command pulses, and they return the snapshot value and the status event strobes.

Strobes are sampled on the system clock. A write takes effect on the clock edge after its strobe ends. The read bus is enabled only while a qualified read is in progress; the output-enable signal stands in for the three-state control. Status events are collected into sticky pending flags. An axis's flags are cleared when a read of that axis's status slot ends. A per-axis mask byte selects which pending flags pull the shared active-low interrupt line.

Top module: `mxc_hostbus`

## Requirements
- R1: After reset, every mode byte, preset value, mask byte and pending flag is zero, no command pulse is high, `irq_n` is 1 and `bus_oe` is 0.
- R2: `bus_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. While `bus_oe` is 0, `bus_dout` is 0.
- R3: A write commits on the first clock edge at which `cs_n` or `wr_n` is found high after a clock edge that found both low. The address and data used are those sampled while the strobes were low, and only the selected axis changes. Slot 0 holds mode byte A, which reads back unchanged.
- R4: Slots 2, 3 and 4 write preset bits 7:0, 15:8 and 23:16 of the selected axis. Each write changes only that byte.
- R5: Reads of slots 2, 3 and 4 return bits 7:0, 15:8 and 23:16 of the selected axis's snapshot input `ax_snap`. The preset is never readable.
- R6: Slot 1 holds mode byte B. Only bits 4:0 are stored, and bits 7:5 always read as 0.
- R7: On the commit edge of a slot 1 write, data bit 5 raises `ax_load_p`, bit 6 raises `ax_snap_p` and bit 7 raises `ax_sclr_p` for the selected axis only. Each pulse lasts one clock.
- R8: Each high bit of an axis's `ax_evt` byte sets the matching pending flag, and slot 5 returns that axis's pending byte. The axis's flags clear on the clock edge after a slot 5 read of that axis ends, or on the commit of a slot 1 write with bit 7 set. An event arriving in the same clock is kept.
- R9: Slot 6 holds a readable mask byte per axis. `irq_n` is 0 exactly when some axis has a pending flag whose mask bit is 1.
- R10: Writes to slots 5 and 7 change no register. Slot 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rsel | input | 3 | Register slot select |
| chsel | input | 2 | Axis select |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| bus_oe | output | 1 | Read bus drive enable |
| ax_mode_a | output | 32 | Mode byte A, 8 bits per axis |
| ax_mode_b | output | 32 | Mode byte B, 8 bits per axis |
| ax_preset | output | 96 | Preset value, 24 bits per axis |
| ax_load_p | output | 4 | Load-counter-from-preset pulse per axis |
| ax_snap_p | output | 4 | Capture-counter-to-snapshot pulse per axis |
| ax_sclr_p | output | 4 | Status reset pulse per axis |
| ax_snap | input | 96 | Counter snapshot, 24 bits per axis |
| ax_evt | input | 32 | Status event strobes, 8 per axis |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Read data is combinational from the slot and axis inputs, so the bench samples it 1 ns after it drives a read address, while the strobes are still low. A write's register and pulse outputs change on the second rising edge after the strobes go low, which is the first edge after they are released. The bench checks these outputs at the falling edge just after that edge, and it checks that each pulse has dropped at the falling edge after that. Pending flags and `irq_n` change one clock after an event or the end of a status read. The bench compares them at the next falling edge, against a model of every axis kept in bench arithmetic, across sweeps over every axis and every slot.

// File: rtl/mxc_pkg.sv
package mxc_pkg;
  localparam int unsigned RSEL_W = 3;

  typedef enum logic [RSEL_W-1:0] {
    RS_MODE_A = 3'd0,
    RS_MODE_B = 3'd1,
    RS_BYTE0  = 3'd2,
    RS_BYTE1  = 3'd3,
    RS_BYTE2  = 3'd4,
    RS_STATUS = 3'd5,
    RS_IMASK  = 3'd6,
    RS_SPARE  = 3'd7
  } rsel_e;

  // command bit positions in mode byte B
  localparam int unsigned CMD_LOAD_BIT = 5;
  localparam int unsigned CMD_SNAP_BIT = 6;
  localparam int unsigned CMD_SCLR_BIT = 7;
  // stored low bits of mode byte B
  localparam int unsigned MODEB_KEEP_W = 5;
endpackage

// File: rtl/mxc_strobe.sv
module mxc_strobe
  import mxc_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned CHW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [RSEL_W-1:0] rsel,
  input  logic [CHW-1:0]    chsel,
  input  logic [DW-1:0]     din,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic [RSEL_W-1:0] h_rsel,
  output logic [CHW-1:0]    h_ch,
  output logic [DW-1:0]     h_data
);
  logic wr_act, rd_act;
  logic wr_q, rd_q, wr_d, rd_d;
  logic [RSEL_W-1:0] rsel_d;
  logic [CHW-1:0]    ch_d;
  logic [DW-1:0]     data_d;
  logic              hold_en;

  assign wr_act = ~cs_n & ~wr_n;
  assign rd_act = ~cs_n & ~rd_n;

  always_comb begin
    wr_d    = wr_act;
    rd_d    = rd_act;
    hold_en = wr_act | rd_act;
    rsel_d  = h_rsel;
    ch_d    = h_ch;
    data_d  = h_data;
    if (hold_en) begin
      rsel_d = rsel;
      ch_d   = chsel;
      data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      h_rsel <= '0;
      h_ch   <= '0;
      h_data <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      h_rsel <= rsel_d;
      h_ch   <= ch_d;
      h_data <= data_d;
    end
  end

  // end of an access: active on the last edge, inactive now
  assign wr_fire = wr_q & ~wr_act;
  assign rd_fire = rd_q & ~rd_act;

  a_r3_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
endmodule

// File: rtl/mxc_axis.sv
module mxc_axis
  import mxc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_clr,
  input  logic [RSEL_W-1:0] w_rsel,
  input  logic [DW-1:0]     w_data,
  input  logic [DW-1:0]     evt,
  output logic [DW-1:0]     mode_a,
  output logic [DW-1:0]     mode_b,
  output logic [DW-1:0]     mask,
  output logic [DW-1:0]     pend,
  output logic [PW-1:0]     preset,
  output logic              load_p,
  output logic              snap_p,
  output logic              sclr_p,
  output logic              irq
);
  localparam int unsigned NB = PW / DW;

  logic [DW-1:0]           mode_a_d, mask_d, pend_d;
  logic [MODEB_KEEP_W-1:0] keep_q, keep_d;
  logic                    cmd_hit, load_d, snap_d, sclr_d;

  always_comb begin
    cmd_hit  = wr_en && (w_rsel == RS_MODE_B);
    mode_a_d = mode_a;
    keep_d   = keep_q;
    mask_d   = mask;
    if (wr_en && (w_rsel == RS_MODE_A)) mode_a_d = w_data;
    if (cmd_hit)                        keep_d   = w_data[MODEB_KEEP_W-1:0];
    if (wr_en && (w_rsel == RS_IMASK))  mask_d   = w_data;
    load_d = cmd_hit & w_data[CMD_LOAD_BIT];
    snap_d = cmd_hit & w_data[CMD_SNAP_BIT];
    sclr_d = cmd_hit & w_data[CMD_SCLR_BIT];
    pend_d = (pend & ~{DW{rd_clr | sclr_d}}) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a <= '0;
      keep_q <= '0;
      mask   <= '0;
      pend   <= '0;
      load_p <= 1'b0;
      snap_p <= 1'b0;
      sclr_p <= 1'b0;
    end else begin
      mode_a <= mode_a_d;
      keep_q <= keep_d;
      mask   <= mask_d;
      pend   <= pend_d;
      load_p <= load_d;
      snap_p <= snap_d;
      sclr_p <= sclr_d;
    end
  end

  assign mode_b = {{(DW-MODEB_KEEP_W){1'b0}}, keep_q};
  assign irq    = |(pend & mask);

  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam logic [RSEL_W-1:0] CODE = RSEL_W'(int'(RS_BYTE0) + k);
    logic [DW-1:0] byte_q, byte_d;
    logic          hit;

    always_comb begin
      hit    = wr_en && (w_rsel == CODE);
      byte_d = byte_q;
      if (hit) byte_d = w_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign preset[k*DW +: DW] = byte_q;

    a_r4_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (w_rsel == CODE)) |=> $stable(preset[k*DW +: DW]));
  end

  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (w_rsel == RS_MODE_A)) |=> $stable(mode_a));

  a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (load_p || snap_p || sclr_p) |=> !(load_p || snap_p || sclr_p));

  a_r7_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_p) |-> $past(wr_en));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (evt == '0)) |=> (pend == '0));
endmodule

// File: rtl/mxc_hostbus.sv
module mxc_hostbus
  import mxc_pkg::*;
#(
  parameter int unsigned N_AXES = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned PW     = 24,
  parameter int unsigned CHW    = (N_AXES > 1) ? $clog2(N_AXES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [RSEL_W-1:0]    rsel,
  input  logic [CHW-1:0]       chsel,
  input  logic [DW-1:0]        bus_din,
  output logic [DW-1:0]        bus_dout,
  output logic                 bus_oe,
  output logic [N_AXES*DW-1:0] ax_mode_a,
  output logic [N_AXES*DW-1:0] ax_mode_b,
  output logic [N_AXES*PW-1:0] ax_preset,
  output logic [N_AXES-1:0]    ax_load_p,
  output logic [N_AXES-1:0]    ax_snap_p,
  output logic [N_AXES-1:0]    ax_sclr_p,
  input  logic [N_AXES*PW-1:0] ax_snap,
  input  logic [N_AXES*DW-1:0] ax_evt,
  output logic                 irq_n
);
  localparam int unsigned NB = PW / DW;

  logic              wr_fire, rd_fire;
  logic [RSEL_W-1:0] h_rsel;
  logic [CHW-1:0]    h_ch;
  logic [DW-1:0]     h_data;

  logic [DW-1:0]     mode_a_w [N_AXES];
  logic [DW-1:0]     mode_b_w [N_AXES];
  logic [DW-1:0]     mask_w   [N_AXES];
  logic [DW-1:0]     pend_w   [N_AXES];
  logic [N_AXES-1:0] irq_w;
  logic [DW-1:0]     rdata;

  mxc_strobe #(.DW(DW), .CHW(CHW)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .rsel    (rsel),
    .chsel   (chsel),
    .din     (bus_din),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .h_rsel  (h_rsel),
    .h_ch    (h_ch),
    .h_data  (h_data)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic sel;
    assign sel = (h_ch == CHW'(a));

    mxc_axis #(.DW(DW), .PW(PW)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_fire & sel),
      .rd_clr (rd_fire & sel & (h_rsel == RS_STATUS)),
      .w_rsel (h_rsel),
      .w_data (h_data),
      .evt    (ax_evt[a*DW +: DW]),
      .mode_a (mode_a_w[a]),
      .mode_b (mode_b_w[a]),
      .mask   (mask_w[a]),
      .pend   (pend_w[a]),
      .preset (ax_preset[a*PW +: PW]),
      .load_p (ax_load_p[a]),
      .snap_p (ax_snap_p[a]),
      .sclr_p (ax_sclr_p[a]),
      .irq    (irq_w[a])
    );

    assign ax_mode_a[a*DW +: DW] = mode_a_w[a];
    assign ax_mode_b[a*DW +: DW] = mode_b_w[a];
  end

  always_comb begin
    rdata = '0;
    if (int'(chsel) < N_AXES) begin
      case (rsel)
        RS_MODE_A: rdata = mode_a_w[chsel];
        RS_MODE_B: rdata = mode_b_w[chsel];
        RS_STATUS: rdata = pend_w[chsel];
        RS_IMASK:  rdata = mask_w[chsel];
        default:   rdata = '0;
      endcase
      for (int k = 0; k < NB; k++) begin
        if (rsel == RSEL_W'(int'(RS_BYTE0) + k))
          rdata = ax_snap[int'(chsel)*PW + k*DW +: DW];
      end
    end
  end

  assign bus_oe   = ~cs_n & ~rd_n;
  assign bus_dout = bus_oe ? rdata : '0;
  assign irq_n    = ~|irq_w;

  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == '0));

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (mask_w[0] != '0 || mask_w[1 % N_AXES] != '0 ||
                mask_w[2 % N_AXES] != '0 || mask_w[3 % N_AXES] != '0));
endmodule

// File: tb/sim_mxc_hostbus.sv
`timescale 1ns/100ps
module sim_mxc_hostbus;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_n, wr_n;
  logic [2:0]  rsel;
  logic [1:0]  chsel;
  logic [7:0]  bus_din, bus_dout;
  logic        bus_oe;
  logic [31:0] ax_mode_a, ax_mode_b;
  logic [95:0] ax_preset, ax_snap;
  logic [3:0]  ax_load_p, ax_snap_p, ax_sclr_p;
  logic [31:0] ax_evt;
  logic        irq_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0]  m_a [4];
  logic [7:0]  m_mask [4];
  logic [23:0] m_pre [4];

  always #2.5 clk = ~clk;

  mxc_hostbus u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rsel(rsel), .chsel(chsel), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .ax_mode_a(ax_mode_a), .ax_mode_b(ax_mode_b),
    .ax_preset(ax_preset), .ax_load_p(ax_load_p), .ax_snap_p(ax_snap_p),
    .ax_sclr_p(ax_sclr_p), .ax_snap(ax_snap), .ax_evt(ax_evt), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] rs, input int ch, input logic [7:0] d);
    @(negedge clk);
    rsel = rs; chsel = 2'(ch); bus_din = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] rs, input int ch, output logic [7:0] d, output logic oe);
    @(negedge clk);
    rsel = rs; chsel = 2'(ch); cs_n = 1'b0; rd_n = 1'b0;
    #1;
    d = bus_dout; oe = bus_oe;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fire_evt(input int ch, input logic [7:0] v);
    @(negedge clk);
    ax_evt = 32'(v) << (ch*8);
    @(negedge clk);
    ax_evt = '0;
  endtask

  function automatic logic [7:0] snap_byte(input int a, input int k);
    return 8'(a*40 + k*7 + 1);
  endfunction

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    rsel = '0; chsel = '0; bus_din = '0; ax_evt = '0;
    for (int a = 0; a < 4; a++) begin
      m_a[a] = '0; m_mask[a] = '0; m_pre[a] = '0;
      for (int k = 0; k < 3; k++) ax_snap[a*24 + k*8 +: 8] = snap_byte(a, k);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 mode_a", ax_mode_a, 0);
    check("R1 mode_b", ax_mode_b, 0);
    check("R1 preset", ax_preset, 0);
    check("R1 pulses", {ax_load_p, ax_snap_p, ax_sclr_p}, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 bus_oe", bus_oe, 0);

    // R2 drive enable only on qualified read
    cs_n = 1'b0; #1; check("R2 cs only", {bus_oe, bus_dout}, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1; check("R2 rd only", {bus_oe, bus_dout}, 0);
    cs_n = 1'b0; #1; check("R2 both", bus_oe, 1);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);

    // R3 commit timing: nothing changes while the strobe is held
    rsel = 3'd0; chsel = 2'd2; bus_din = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 held strobe", ax_mode_a, 0);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    m_a[2] = 8'h5A;
    check("R3 commit", ax_mode_a, {m_a[3], m_a[2], m_a[1], m_a[0]});

    // R3 mode A sweep over axes, independence
    for (int a = 0; a < 4; a++) begin
      m_a[a] = 8'(8'hC3 ^ (a*29));
      bus_wr(3'd0, a, m_a[a]);
      check("R3 mode_a out", ax_mode_a, {m_a[3], m_a[2], m_a[1], m_a[0]});
    end
    for (int a = 0; a < 4; a++) begin
      bus_rd(3'd0, a, d, oe);
      check("R3 mode_a read", d, m_a[a]);
    end

    // R4 preset bytes, one at a time
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] v;
        v = 8'(a*64 + k*21 + 9);
        m_pre[a][k*8 +: 8] = v;
        bus_wr(3'(2 + k), a, v);
        check("R4 preset", ax_preset, {m_pre[3], m_pre[2], m_pre[1], m_pre[0]});
      end
    end
    bus_wr(3'd3, 1, 8'hEE);
    m_pre[1][15:8] = 8'hEE;
    check("R4 middle only", ax_preset, {m_pre[3], m_pre[2], m_pre[1], m_pre[0]});

    // R5 snapshot bytes through slots 2..4
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 3; k++) begin
        bus_rd(3'(2 + k), a, d, oe);
        check("R5 snapshot byte", d, snap_byte(a, k));
      end
    end

    // R6 mode B stores bits 4:0
    for (int a = 0; a < 4; a++) begin
      bus_wr(3'd1, a, 8'(8'h10 + a + 8'h0A));
      bus_rd(3'd1, a, d, oe);
      check("R6 mode_b read", d, 8'(8'h10 + a + 8'h0A) & 8'h1F);
    end
    bus_wr(3'd1, 0, 8'hFF);
    check("R6 mode_b port", ax_mode_b[7:0], 8'h1F);
    check("R7 all pulses axis0", {ax_load_p, ax_snap_p, ax_sclr_p}, {4'b0001, 4'b0001, 4'b0001});

    // R7 each command bit, each axis
    for (int a = 0; a < 4; a++) begin
      for (int b = 5; b < 8; b++) begin
        logic [3:0] onehot;
        onehot = 4'(1 << a);
        bus_wr(3'd1, a, 8'(1 << b));
        check("R7 pulse", {ax_load_p, ax_snap_p, ax_sclr_p},
              {(b == 5) ? onehot : 4'b0, (b == 6) ? onehot : 4'b0, (b == 7) ? onehot : 4'b0});
        @(negedge clk);
        check("R7 one clock", {ax_load_p, ax_snap_p, ax_sclr_p}, 0);
      end
    end

    // R8 pending status, read-to-clear per axis, mask 0 keeps irq high
    for (int a = 0; a < 4; a++) begin
      fire_evt(a, 8'(8'h81 + a*3));
      check("R9 masked off", irq_n, 1);
    end
    for (int a = 0; a < 4; a++) begin
      bus_rd(3'd5, a, d, oe);
      check("R8 status read", d, 8'(8'h81 + a*3));
      bus_rd(3'd5, a, d, oe);
      check("R8 cleared", d, 0);
    end

    // R9 mask and interrupt
    for (int a = 0; a < 4; a++) begin
      m_mask[a] = 8'(8'h01 << a);
      bus_wr(3'd6, a, m_mask[a]);
      bus_rd(3'd6, a, d, oe);
      check("R9 mask read", d, m_mask[a]);
    end
    fire_evt(2, 8'h02);
    check("R9 unmasked bit no irq", irq_n, 1);
    fire_evt(2, 8'h04);
    check("R9 irq asserted", irq_n, 0);
    bus_rd(3'd5, 1, d, oe);
    check("R9 other axis read keeps irq", irq_n, 0);
    bus_rd(3'd5, 2, d, oe);
    check("R8 pending value", d, 8'h06);
    check("R9 irq released", irq_n, 1);

    // R8 status reset command clears pending
    fire_evt(3, 8'h08);
    check("R9 irq axis3", irq_n, 0);
    bus_wr(3'd1, 3, 8'h80);
    check("R8 sclr clears irq", irq_n, 1);
    bus_rd(3'd5, 3, d, oe);
    check("R8 sclr cleared", d, 0);

    // R10 writes to slots 5 and 7 ignored, slot 7 reads 0
    fire_evt(0, 8'h30);
    bus_wr(3'd5, 0, 8'h00);
    bus_wr(3'd7, 0, 8'hFF);
    check("R10 regs untouched", {ax_mode_a, ax_preset},
          {m_a[3], m_a[2], m_a[1], m_a[0], m_pre[3], m_pre[2], m_pre[1], m_pre[0]});
    bus_rd(3'd7, 0, d, oe);
    check("R10 spare read", d, 0);
    bus_rd(3'd5, 0, d, oe);
    check("R10 status kept", d, 8'h30);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule